// File: doc/BRIEF.md
# Single-Cycle 32-bit Integer Core

This block is a small 32-bit processor core that fetches, decodes, executes and retires one instruction on every clock edge. It handles nine operations: four register-register logic and arithmetic forms, a signed set-on-less-than, a word load, a word store, a branch-if-equal and an absolute jump. Instruction storage and data storage are two separate internal arrays, so a load or store can reach data storage while the same instruction is being fetched. The incrementer, the branch-target adder and the main ALU are three separate adders, so no hardware is shared across time.

Programs and initial data are placed directly into the internal arrays by the surrounding environment while reset is held. After `rst_n` rises, a two-stage synchronizer releases the core. The first instruction retires on the third rising edge after the release. The core exposes its program counter and both write buses, register-file and data-storage. It drives these buses combinationally for the instruction at the current PC, and the write takes effect on the next rising edge.

Top module: `sc_core`

## Requirements
- R1: While `rst_n` is low, and for the two rising edges after it rises, `pc_o` is 0 and both `rf_we_o` and `dm_we_o` are low. The instruction at address 0 retires on the third rising edge after `rst_n` rises.
- R2: An instruction that neither branches nor jumps advances the PC by 4.
- R3: R-type instructions (opcode 0) with funct 0x20 add, 0x22 subtract, 0x24 AND and 0x25 OR take rs (bits 25-21) and rt (bits 20-16) and write the result to rd (bits 15-11).
- R4: R-type funct 0x2A writes 1 to rd when rs < rt as signed 32-bit values, and 0 otherwise.
- R5: Opcode 0x23 loads the word at rs + sign-extended bits 15-0 into rt (bits 20-16). Data storage is word addressed by address bits above bit 1.
- R6: Opcode 0x2B stores rt to address rs + sign-extended offset, with `dm_we_o` high. A store writes no register.
- R7: Opcode 0x04 compares rs with rt. If they are equal, the next PC is (PC+4) + (sign-extended offset << 2), and the offset may be negative. Otherwise the next PC is PC+4. A branch writes nothing.
- R8: Opcode 0x02 sets the next PC to {PC[31:28], bits 25-0, 2'b00} and writes nothing.
- R9: Register 0 always reads as zero. A write addressed to it has no effect.
- R10: Any other opcode, and R-type with any other funct, writes nothing and advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_o | output | 32 | Address of the instruction now executing |
| rf_we_o | output | 1 | Register write of this instruction is enabled |
| rf_waddr_o | output | 5 | Destination register number |
| rf_wdata_o | output | 32 | Write-back value |
| dm_we_o | output | 1 | Data-storage write of this instruction is enabled |
| dm_addr_o | output | 32 | Data address (ALU result) |
| dm_wdata_o | output | 32 | Store data (rt value) |

## Verification
A wrong decode or a wrong operand mux shows on the write buses in the same cycle that the faulty instruction sits at `pc_o`. A corrupted register or memory word stays hidden until a later instruction reads it, so every value the programs load or compute is later stored or combined, which brings it back out on `dm_wdata_o` or `rf_wdata_o` within a few cycles. A wrong next-PC choice shows on `pc_o` at the very next cycle. The programs therefore place branches, with and without the branch taken and in both directions, next to instructions whose addresses are checked.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int XLEN = 32;
  localparam int RIDX = 5;

  localparam logic [5:0] OPC_RTYPE = 6'h00;
  localparam logic [5:0] OPC_JUMP  = 6'h02;
  localparam logic [5:0] OPC_BEQ   = 6'h04;
  localparam logic [5:0] OPC_LOAD  = 6'h23;
  localparam logic [5:0] OPC_STORE = 6'h2B;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT
  } alu_fn_e;

  typedef enum logic [1:0] {
    AMODE_ADD  = 2'b00,
    AMODE_SUB  = 2'b01,
    AMODE_FUNC = 2'b10
  } alu_mode_e;

  typedef struct packed {
    logic    reg_write;
    logic    reg_dst;
    logic    alu_src;
    logic    mem_to_reg;
    logic    mem_write;
    logic    branch;
    logic    jump;
    alu_fn_e alu_fn;
  } ctrl_t;
endpackage

// File: rtl/sc_ctrl.sv
module sc_ctrl
  import sc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [5:0]  opcode,
  input  logic [5:0]  funct,
  output ctrl_t       ctrl
);
  alu_mode_e mode;
  logic      funct_ok;

  always_comb begin
    funct_ok = 1'b1;
    case (funct)
      FN_ADD, FN_SUB, FN_AND, FN_OR, FN_SLT: funct_ok = 1'b1;
      default:                               funct_ok = 1'b0;
    endcase
  end

  // main decode
  always_comb begin
    ctrl = '0;
    ctrl.alu_fn = ALU_ADD;
    mode = AMODE_ADD;
    case (opcode)
      OPC_RTYPE: begin
        ctrl.reg_write = funct_ok;
        ctrl.reg_dst   = 1'b1;
        mode           = AMODE_FUNC;
      end
      OPC_LOAD: begin
        ctrl.reg_write  = 1'b1;
        ctrl.alu_src    = 1'b1;
        ctrl.mem_to_reg = 1'b1;
      end
      OPC_STORE: begin
        ctrl.alu_src   = 1'b1;
        ctrl.mem_write = 1'b1;
      end
      OPC_BEQ: begin
        ctrl.branch = 1'b1;
        mode        = AMODE_SUB;
      end
      OPC_JUMP: ctrl.jump = 1'b1;
      default: ;
    endcase

    // second-level ALU decode
    case (mode)
      AMODE_SUB:  ctrl.alu_fn = ALU_SUB;
      AMODE_FUNC: begin
        case (funct)
          FN_SUB:  ctrl.alu_fn = ALU_SUB;
          FN_AND:  ctrl.alu_fn = ALU_AND;
          FN_OR:   ctrl.alu_fn = ALU_OR;
          FN_SLT:  ctrl.alu_fn = ALU_SLT;
          default: ctrl.alu_fn = ALU_ADD;
        endcase
      end
      default:    ctrl.alu_fn = ALU_ADD;
    endcase
  end

  AST_ONE_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctrl.reg_write, ctrl.mem_write, ctrl.branch, ctrl.jump})); // R10
  AST_STORE_NO_RF: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.mem_write |-> (!ctrl.reg_write && ctrl.alu_src)); // R6
  AST_LOAD_TO_RT: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.mem_to_reg |-> (!ctrl.reg_dst && ctrl.alu_src)); // R5
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
(
  input  alu_fn_e           fn,
  input  logic [XLEN-1:0]   a,
  input  logic [XLEN-1:0]   b,
  output logic [XLEN-1:0]   y,
  output logic              zero
);
  logic [XLEN-1:0] diff;

  assign diff = a - b;

  always_comb begin
    case (fn)
      ALU_SUB: y = diff;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SLT: y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = a + b;
    endcase
  end

  assign zero = (y == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile
  import sc_pkg::*;
(
  input  logic              clk,
  input  logic              we,
  input  logic [RIDX-1:0]   waddr,
  input  logic [XLEN-1:0]   wdata,
  input  logic [RIDX-1:0]   raddr_a,
  input  logic [RIDX-1:0]   raddr_b,
  output logic [XLEN-1:0]   rdata_a,
  output logic [XLEN-1:0]   rdata_b
);
  localparam int NREG = 1 << RIDX;

  logic [XLEN-1:0] regs [1:NREG-1];
  logic            wr_en;

  assign wr_en = we && (waddr != '0);

  always_ff @(posedge clk) begin
    if (wr_en) regs[waddr] <= wdata;
  end

  assign rdata_a = (raddr_a == '0) ? '0 : regs[raddr_a];
  assign rdata_b = (raddr_b == '0) ? '0 : regs[raddr_b];
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [31:0] pc_o,
  output logic        rf_we_o,
  output logic [4:0]  rf_waddr_o,
  output logic [31:0] rf_wdata_o,
  output logic        dm_we_o,
  output logic [31:0] dm_addr_o,
  output logic [31:0] dm_wdata_o
);
  localparam int IA_W = $clog2(IMEM_WORDS);
  localparam int DA_W = $clog2(DMEM_WORDS);

  logic [XLEN-1:0] imem [IMEM_WORDS];
  logic [XLEN-1:0] dmem [DMEM_WORDS];

  // reset release synchronizer
  logic [1:0] rel_q;
  logic       run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rel_q <= 2'b00;
    else        rel_q <= {rel_q[0], 1'b1};
  end
  assign run = rel_q[1];

  // program counter: next-state and register
  logic [XLEN-1:0] pc_q, pc_d, pc_plus4, br_target, jmp_target;
  logic [XLEN-1:0] ir, sext_imm;
  logic            take_branch;
  ctrl_t           ctrl;

  assign ir         = imem[pc_q[IA_W+1:2]];
  assign sext_imm   = {{16{ir[15]}}, ir[15:0]};
  assign pc_plus4   = pc_q + 32'd4;
  assign br_target  = pc_plus4 + {sext_imm[XLEN-3:0], 2'b00};
  assign jmp_target = {pc_q[31:28], ir[25:0], 2'b00};

  logic            alu_zero;
  logic [XLEN-1:0] alu_y;

  assign take_branch = ctrl.branch & alu_zero;

  always_comb begin
    if (ctrl.jump)        pc_d = jmp_target;
    else if (take_branch) pc_d = br_target;
    else                  pc_d = pc_plus4;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pc_q <= '0;
    else if (run) pc_q <= pc_d;
  end

  sc_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .opcode (ir[31:26]),
    .funct  (ir[5:0]),
    .ctrl   (ctrl)
  );

  // register file and operand selection
  logic [XLEN-1:0] rs_val, rt_val, alu_b, wb_data, dm_rdata;
  logic [RIDX-1:0] dst;
  logic            rf_we, dm_we;

  assign dst   = ctrl.reg_dst ? ir[15:11] : ir[20:16];
  assign rf_we = ctrl.reg_write & run;
  assign dm_we = ctrl.mem_write & run;

  sc_regfile u_rf (
    .clk     (clk),
    .we      (rf_we),
    .waddr   (dst),
    .wdata   (wb_data),
    .raddr_a (ir[25:21]),
    .raddr_b (ir[20:16]),
    .rdata_a (rs_val),
    .rdata_b (rt_val)
  );

  assign alu_b = ctrl.alu_src ? sext_imm : rt_val;

  sc_alu u_alu (
    .fn   (ctrl.alu_fn),
    .a    (rs_val),
    .b    (alu_b),
    .y    (alu_y),
    .zero (alu_zero)
  );

  // data storage
  assign dm_rdata = dmem[alu_y[DA_W+1:2]];

  always_ff @(posedge clk) begin
    if (dm_we) dmem[alu_y[DA_W+1:2]] <= rt_val;
  end

  assign wb_data = ctrl.mem_to_reg ? dm_rdata : alu_y;

  assign pc_o       = pc_q;
  assign rf_we_o    = rf_we;
  assign rf_waddr_o = dst;
  assign rf_wdata_o = wb_data;
  assign dm_we_o    = dm_we;
  assign dm_addr_o  = alu_y;
  assign dm_wdata_o = rt_val;

  AST_HOLD_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pc_q == '0)); // R1
  AST_QUIET_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!rf_we_o && !dm_we_o)); // R1
  AST_SEQ_PC: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !ctrl.branch && !ctrl.jump) |=> (pc_q == $past(pc_q) + 32'd4)); // R2
  AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    pc_q[1:0] == 2'b00); // R7
  AST_JUMP_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    (run && ctrl.jump) |=> (pc_q[31:28] == $past(pc_q[31:28]))); // R8
endmodule

// File: tb/test_sc_core.sv
module test_sc_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pc_o, rf_wdata_o, dm_addr_o, dm_wdata_o;
  logic [4:0]  rf_waddr_o;
  logic        rf_we_o, dm_we_o;
  int          n_run = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  sc_core i_sc_core (
    .clk(clk), .rst_n(rst_n), .pc_o(pc_o),
    .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o),
    .dm_we_o(dm_we_o), .dm_addr_o(dm_addr_o), .dm_wdata_o(dm_wdata_o)
  );

  function automatic logic [31:0] rt_op(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
  endfunction
  function automatic logic [31:0] it_op(logic [5:0] op, int rs, int rt, int imm);
    return {op, rs[4:0], rt[4:0], imm[15:0]};
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // one instruction: sample between edges, then let it retire
  task automatic step(string req, logic [31:0] epc, logic ewe, int ewa,
                      logic [31:0] ewd, logic edwe, logic [31:0] eda, logic [31:0] edd);
    @(negedge clk);
    check(req, "pc", pc_o, epc);
    check(req, "rf_we", {31'd0, rf_we_o}, {31'd0, ewe});
    if (ewe) begin
      check(req, "rf_waddr", {27'd0, rf_waddr_o}, ewa);
      check(req, "rf_wdata", rf_wdata_o, ewd);
    end
    check(req, "dm_we", {31'd0, dm_we_o}, {31'd0, edwe});
    if (edwe) begin
      check(req, "dm_addr", dm_addr_o, eda);
      check(req, "dm_wdata", dm_wdata_o, edd);
    end
  endtask

  task automatic start_core();
    rst_n = 1'b0;
    @(negedge clk);
    for (int k = 0; k < 64; k++) begin
      i_sc_core.imem[k] = 32'hFC00_0000;
      i_sc_core.dmem[k] = 32'd0;
    end
  endtask

  task automatic release_core();
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
  endtask

  task automatic t_reset();
    start_core();
    repeat (2) begin
      @(negedge clk);
      check("R1", "pc in reset", pc_o, 32'd0);
      check("R1", "writes in reset", {30'd0, rf_we_o, dm_we_o}, 32'd0);
    end
    i_sc_core.imem[0] = it_op(6'h2B, 0, 0, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1", "pc while syncing", pc_o, 32'd0);
    check("R1", "no store while syncing", {31'd0, dm_we_o}, 32'd0);
    @(negedge clk);
    check("R1", "first store visible", {31'd0, dm_we_o}, 32'd1);
    @(negedge clk);
    check("R1", "first retire pc", pc_o, 32'd4);
  endtask

  task automatic t_alu();
    start_core();
    i_sc_core.dmem[0] = 32'd7;
    i_sc_core.dmem[1] = 32'hFFFF_FFFD;
    i_sc_core.dmem[2] = 32'h0F0F_00FF;
    i_sc_core.imem[0]  = it_op(6'h23, 0, 1, 0);
    i_sc_core.imem[1]  = it_op(6'h23, 0, 2, 4);
    i_sc_core.imem[2]  = it_op(6'h23, 0, 3, 8);
    i_sc_core.imem[3]  = rt_op(1, 2, 4, 6'h20);
    i_sc_core.imem[4]  = rt_op(1, 2, 5, 6'h22);
    i_sc_core.imem[5]  = rt_op(1, 3, 6, 6'h24);
    i_sc_core.imem[6]  = rt_op(2, 3, 7, 6'h25);
    i_sc_core.imem[7]  = rt_op(2, 1, 8, 6'h2A);
    i_sc_core.imem[8]  = rt_op(1, 2, 9, 6'h2A);
    i_sc_core.imem[9]  = rt_op(1, 1, 0, 6'h20);
    i_sc_core.imem[10] = it_op(6'h2B, 0, 0, 12);
    i_sc_core.imem[11] = it_op(6'h2B, 8, 5, 15);
    i_sc_core.imem[12] = rt_op(1, 2, 10, 6'h07);
    i_sc_core.imem[13] = it_op(6'h23, 0, 11, 16);
    release_core();
    step("R5", 0,  1, 1, 32'd7, 0, 0, 0);
    step("R5", 4,  1, 2, 32'hFFFF_FFFD, 0, 0, 0);
    step("R5", 8,  1, 3, 32'h0F0F_00FF, 0, 0, 0);
    step("R3", 12, 1, 4, 32'd4, 0, 0, 0);
    step("R3", 16, 1, 5, 32'd10, 0, 0, 0);
    step("R3", 20, 1, 6, 32'd7, 0, 0, 0);
    step("R3", 24, 1, 7, 32'hFFFF_FFFF, 0, 0, 0);
    step("R4", 28, 1, 8, 32'd1, 0, 0, 0);
    step("R4", 32, 1, 9, 32'd0, 0, 0, 0);
    step("R9", 36, 1, 0, 32'd14, 0, 0, 0);
    step("R9", 40, 0, 0, 0, 1, 32'd12, 32'd0);
    step("R6", 44, 0, 0, 0, 1, 32'd16, 32'd10);
    step("R10", 48, 0, 0, 0, 0, 0, 0);
    step("R6", 52, 1, 11, 32'd10, 0, 0, 0);
    step("R2", 56, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_flow();
    start_core();
    i_sc_core.dmem[0] = 32'd5;
    i_sc_core.dmem[1] = 32'd9;
    i_sc_core.imem[0]  = it_op(6'h23, 0, 1, 0);
    i_sc_core.imem[1]  = it_op(6'h23, 0, 2, 0);
    i_sc_core.imem[2]  = it_op(6'h04, 1, 2, 2);
    i_sc_core.imem[5]  = it_op(6'h04, 1, 0, 5);
    i_sc_core.imem[6]  = it_op(6'h04, 0, 0, -3);
    i_sc_core.imem[4]  = {6'h02, 26'h10};
    i_sc_core.imem[16] = it_op(6'h23, 0, 3, 4);
    i_sc_core.imem[17] = it_op(6'h2B, 0, 3, 8);
    i_sc_core.imem[18] = it_op(6'h23, 0, 4, 8);
    i_sc_core.imem[19] = 32'hFC00_0000;
    i_sc_core.imem[20] = {6'h02, 26'h3FF_FFFF};
    release_core();
    step("R5", 0, 1, 1, 32'd5, 0, 0, 0);
    step("R5", 4, 1, 2, 32'd5, 0, 0, 0);
    step("R7", 8, 0, 0, 0, 0, 0, 0);
    step("R7", 20, 0, 0, 0, 0, 0, 0);
    step("R7", 24, 0, 0, 0, 0, 0, 0);
    step("R8", 16, 0, 0, 0, 0, 0, 0);
    step("R8", 64, 1, 3, 32'd9, 0, 0, 0);
    step("R6", 68, 0, 0, 0, 1, 32'd8, 32'd9);
    step("R6", 72, 1, 4, 32'd9, 0, 0, 0);
    step("R10", 76, 0, 0, 0, 0, 0, 0);
    step("R8", 80, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    check("R8", "far jump pc", pc_o, 32'h0FFF_FFFC);
  endtask

  initial begin
    t_reset();
    t_alu();
    t_flow();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule